// File: doc/BRIEF.md
# Handshaked Command/Response Link Sequencer

This block is the host half of a byte-serial link to a power-management microcontroller. A request is an opcode with zero or more data bytes. The block moves each byte through an external shift register. A byte transfer is framed by an active-low request line driven by the host and an active-low acknowledge line driven by the microcontroller. Before a request is accepted, the block asks a per-opcode lookup two questions: how many bytes go out with this opcode, and how many come back. Either answer may be "variable". A variable send count puts an explicit length byte on the wire. A variable reply count means the first received byte is the reply length.

A separate attention input tells the host that the microcontroller has an unsolicited packet. A rising edge on it is latched. When the sequencer is next idle, the latched event is served ahead of any waiting request: the block sends a fixed interrupt-acknowledge opcode, reads a length-prefixed packet and stores it in a small interrupt buffer. Software reads that buffer through a dedicated port.

A request may also be marked as one whose real answer arrives later inside an interrupt packet. Only one such request may be outstanding. The host clears the outstanding mark once it has seen the answer.

Top module: `pmlink_seq`

## Requirements
- R1: After reset, treq_n is 1 and req_accept, req_reject, sr_load, rx_valid, done, err_timeout and err_badlen are all 0.
- R2: Every byte starts with a one-cycle sr_load, with sr_dir set to 1 for a byte going out and 0 for a byte coming in, and treq_n driven low. treq_n goes back high after sr_done. No further sr_load happens until tack_n has been seen high again.
- R3: A request is sent as follows: first the opcode. Then, only when lut_send is 8'hFF, one byte equal to req_nbytes−1. Then data bytes 1 to req_nbytes−1, in order, where byte k is req_data[8k+7:8k].
- R4: A request is refused with a one-cycle req_reject, and nothing is sent, in any of these cases: req_nbytes is 0; req_nbytes is greater than 32; lut_send is a fixed count n (anything other than 8'hFF) and req_nbytes is not n+1.
- R5: When lut_reply is 0, done pulses with done_count 0 right after the last byte is sent. When lut_reply is a fixed count n, the block receives n bytes, presents each on rx_data with rx_valid, then pulses done with done_count n.
- R6: When lut_reply is 8'hFF, the first received byte L is the reply length and does not appear on rx_data. L further bytes follow on rx_data. An L of 0 completes at once with done_count 0.
- R7: A received length byte greater than 32 gives a one-cycle err_badlen. No done follows, and the block returns to idle.
- R8: If tack_n stays low for ACK_TMO cycles after a byte, err_timeout pulses once. The request is dropped without a done, and the block returns to idle.
- R9: A rising edge on attn is latched and served only from idle. The block sends INTACK_OP and reads a length-prefixed packet; those bytes appear with rx_intr set. done then pulses with done_intr set and done_count equal to the packet length.
- R10: If attention is pending when the block becomes idle, the interrupt-acknowledge transfer goes out before any request already waiting on req_valid.
- R11: Byte i of the interrupt packet is stored at interrupt-buffer address i. ibuf_rdata shows the byte at ibuf_raddr one cycle after the address is applied.
- R12: A request completed with req_deferred set marks a deferred reply outstanding. A further request with req_deferred set is neither accepted nor rejected until a defer_clr pulse arrives. A request with req_deferred clear is still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is offered; held until accept or reject |
| req_opcode | input | 8 | Opcode of the offered request |
| req_nbytes | input | NBW | Total byte count including the opcode |
| req_data | input | MAXB*8 | Request bytes; byte k at bits 8k+7:8k |
| req_deferred | input | 1 | Request's reply arrives later in an interrupt packet |
| req_accept | output | 1 | One-cycle pulse: request taken |
| req_reject | output | 1 | One-cycle pulse: request refused |
| defer_clr | input | 1 | Clears the outstanding deferred-reply mark |
| lut_op | output | 8 | Opcode presented to the length lookup |
| lut_send | input | 8 | Data bytes sent after the opcode, 8'hFF = length byte |
| lut_reply | input | 8 | Reply bytes, 8'hFF = length-prefixed |
| treq_n | output | 1 | Active-low transfer request |
| tack_n | input | 1 | Active-low transfer acknowledge |
| sr_load | output | 1 | One-cycle pulse: start a shift-register byte |
| sr_dir | output | 1 | 1 = shift out, 0 = shift in on external clock |
| sr_out | output | 8 | Byte to shift out |
| sr_done | input | 1 | Shift register finished the byte |
| sr_in | input | 8 | Byte shifted in |
| attn | input | 1 | Attention line; rising edge requests service |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | rx_data valid this cycle |
| rx_intr | output | 1 | rx_data belongs to an interrupt packet |
| done | output | 1 | One-cycle completion pulse |
| done_count | output | NBW | Bytes received by the completed transfer |
| done_intr | output | 1 | Completion was an interrupt packet |
| err_timeout | output | 1 | Acknowledge timeout pulse |
| err_badlen | output | 1 | Received length over 32 |
| ibuf_raddr | input | AW | Interrupt buffer read address |
| ibuf_rdata | output | 8 | Interrupt buffer read data, one cycle latency |

## Verification
The assertions assume the following about the inputs. sr_done pulses only while a byte is in flight, that is, after sr_load and before treq_n goes high. The lookup returns fixed reply counts of 32 or less. req_valid and the request fields stay stable until req_accept or req_reject. The bench keeps within these rules by driving the shift-register side from a responder model. That model raises sr_done only a few cycles after it sees sr_load, and releases tack_n only after treq_n is high. The bench's lookup gives small fixed counts, and its request task holds the fields until it sees one of the two pulses.

// File: rtl/pmlink_pkg.sv
package pmlink_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_INTACK,
    ST_RDREPLY,
    ST_RDINTR
  } pml_state_t;

  localparam logic [7:0] PML_VAR = 8'hFF;
endpackage

// File: rtl/pmlink_attn.sv
module pmlink_attn (
  input  logic clk,
  input  logic rst,
  input  logic attn,
  input  logic take,
  output logic pend
);
  logic s1, s2, s3;
  logic rise;

  assign rise = s2 & ~s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      s3   <= 1'b0;
      pend <= 1'b0;
    end else begin
      s1 <= attn;
      s2 <= s1;
      s3 <= s2;
      if (rise)      pend <= 1'b1;
      else if (take) pend <= 1'b0;
    end
  end

  // R9
  edge_set_chk: assert property (@(posedge clk) disable iff (rst) rise |=> pend);
endmodule

// File: rtl/pmlink_ackwait.sv
module pmlink_ackwait #(
  parameter int TMO = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic ack_n,
  output logic ok,
  output logic expired
);
  localparam int CW = $clog2(TMO + 1);

  logic          busy;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cnt     <= '0;
      ok      <= 1'b0;
      expired <= 1'b0;
    end else begin
      ok      <= 1'b0;
      expired <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy) begin
        if (ack_n) begin
          ok   <= 1'b1;
          busy <= 1'b0;
        end else if (cnt == CW'(TMO - 1)) begin
          expired <= 1'b1;
          busy    <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R8
  tmo_window_chk: assert property (@(posedge clk) disable iff (rst)
    expired |-> ($past(busy) && !$past(ack_n)));

  // R2
  ok_excl_chk: assert property (@(posedge clk) disable iff (rst) !(ok && expired));
endmodule

// File: rtl/pmlink_ibuf.sv
module pmlink_ibuf #(
  parameter int DEPTH = 32,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pmlink_seq.sv
module pmlink_seq
  import pmlink_pkg::*;
#(
  parameter int         MAXB      = 32,
  parameter int         NBW       = $clog2(MAXB + 1),
  parameter int         AW        = $clog2(MAXB),
  parameter int         ACK_TMO   = 64,
  parameter logic [7:0] INTACK_OP = 8'h78
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [7:0]        req_opcode,
  input  logic [NBW-1:0]    req_nbytes,
  input  logic [MAXB*8-1:0] req_data,
  input  logic              req_deferred,
  output logic              req_accept,
  output logic              req_reject,
  input  logic              defer_clr,
  output logic [7:0]        lut_op,
  input  logic [7:0]        lut_send,
  input  logic [7:0]        lut_reply,
  output logic              treq_n,
  input  logic              tack_n,
  output logic              sr_load,
  output logic              sr_dir,
  output logic [7:0]        sr_out,
  input  logic              sr_done,
  input  logic [7:0]        sr_in,
  input  logic              attn,
  output logic [7:0]        rx_data,
  output logic              rx_valid,
  output logic              rx_intr,
  output logic              done,
  output logic [NBW-1:0]    done_count,
  output logic              done_intr,
  output logic              err_timeout,
  output logic              err_badlen,
  input  logic [AW-1:0]     ibuf_raddr,
  output logic [7:0]        ibuf_rdata
);
  localparam logic [7:0] MAXB8 = 8'(MAXB);

  pml_state_t     st;
  logic           ph_ack;
  logic [NBW-1:0] idx, cur_nb, rcnt, rcnt_inc;
  logic           len_pend, cur_def, awaiting;
  logic [7:0]     cur_op, rlen, rxb;
  logic           rlen_var;
  logic [7:0]     cur_data [MAXB];
  logic           pend, take, aw_start, aw_ok, aw_exp;
  logic           fits, ib_we;

  assign lut_op   = (st == ST_IDLE) ? req_opcode : cur_op;
  assign take     = (st == ST_IDLE) && pend;
  assign aw_start = sr_done && !ph_ack && (st != ST_IDLE);
  assign rcnt_inc = rcnt + 1'b1;
  assign fits     = (req_nbytes != '0) && (8'(req_nbytes) <= MAXB8) &&
                    ((lut_send == PML_VAR) || (lut_send + 8'd1 == 8'(req_nbytes)));
  assign ib_we    = (st == ST_RDINTR) && ph_ack && aw_ok && !rlen_var;

  pmlink_attn u_attn (
    .clk (clk), .rst (rst), .attn (attn), .take (take), .pend (pend)
  );

  pmlink_ackwait #(.TMO(ACK_TMO)) u_ackwait (
    .clk (clk), .rst (rst), .start (aw_start), .ack_n (tack_n),
    .ok (aw_ok), .expired (aw_exp)
  );

  pmlink_ibuf #(.DEPTH(MAXB), .AW(AW)) u_ibuf (
    .clk (clk), .we (ib_we), .waddr (rcnt[AW-1:0]), .wdata (rxb),
    .raddr (ibuf_raddr), .rdata (ibuf_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      ph_ack      <= 1'b0;
      idx         <= '0;
      cur_nb      <= '0;
      rcnt        <= '0;
      len_pend    <= 1'b0;
      cur_def     <= 1'b0;
      awaiting    <= 1'b0;
      cur_op      <= '0;
      rlen        <= '0;
      rlen_var    <= 1'b0;
      rxb         <= '0;
      treq_n      <= 1'b1;
      sr_load     <= 1'b0;
      sr_dir      <= 1'b1;
      sr_out      <= '0;
      req_accept  <= 1'b0;
      req_reject  <= 1'b0;
      rx_data     <= '0;
      rx_valid    <= 1'b0;
      rx_intr     <= 1'b0;
      done        <= 1'b0;
      done_count  <= '0;
      done_intr   <= 1'b0;
      err_timeout <= 1'b0;
      err_badlen  <= 1'b0;
      for (int k = 0; k < MAXB; k++) cur_data[k] <= '0;
    end else begin
      sr_load     <= 1'b0;
      req_accept  <= 1'b0;
      req_reject  <= 1'b0;
      rx_valid    <= 1'b0;
      done        <= 1'b0;
      err_timeout <= 1'b0;
      err_badlen  <= 1'b0;
      if (defer_clr) awaiting <= 1'b0;

      if (aw_start) begin
        treq_n <= 1'b1;
        ph_ack <= 1'b1;
        rxb    <= sr_in;
      end

      if (st == ST_IDLE) begin
        if (pend) begin
          sr_load <= 1'b1;
          sr_dir  <= 1'b1;
          sr_out  <= INTACK_OP;
          treq_n  <= 1'b0;
          ph_ack  <= 1'b0;
          st      <= ST_INTACK;
        end else if (req_valid) begin
          if (!fits) begin
            req_reject <= 1'b1;
          end else if (!(req_deferred && awaiting)) begin
            req_accept <= 1'b1;
            cur_op     <= req_opcode;
            cur_nb     <= req_nbytes;
            cur_def    <= req_deferred;
            len_pend   <= (lut_send == PML_VAR);
            idx        <= NBW'(1);
            for (int k = 0; k < MAXB; k++) cur_data[k] <= req_data[8*k +: 8];
            sr_load    <= 1'b1;
            sr_dir     <= 1'b1;
            sr_out     <= req_opcode;
            treq_n     <= 1'b0;
            ph_ack     <= 1'b0;
            st         <= ST_SEND;
          end
        end
      end else if (ph_ack && aw_exp) begin
        err_timeout <= 1'b1;
        ph_ack      <= 1'b0;
        st          <= ST_IDLE;
      end else if (ph_ack && aw_ok) begin
        ph_ack <= 1'b0;
        unique case (st)
          ST_SEND: begin
            if (len_pend) begin
              len_pend <= 1'b0;
              sr_load  <= 1'b1;
              sr_dir   <= 1'b1;
              sr_out   <= 8'(cur_nb - 1'b1);
              treq_n   <= 1'b0;
            end else if (idx < cur_nb) begin
              idx     <= idx + 1'b1;
              sr_load <= 1'b1;
              sr_dir  <= 1'b1;
              sr_out  <= cur_data[idx[AW-1:0]];
              treq_n  <= 1'b0;
            end else if (lut_reply == 8'd0) begin
              done       <= 1'b1;
              done_count <= '0;
              done_intr  <= 1'b0;
              st         <= ST_IDLE;
              if (cur_def) awaiting <= 1'b1;
            end else begin
              rlen_var <= (lut_reply == PML_VAR);
              rlen     <= lut_reply;
              rcnt     <= '0;
              st       <= ST_RDREPLY;
              sr_load  <= 1'b1;
              sr_dir   <= 1'b0;
              treq_n   <= 1'b0;
            end
          end
          ST_INTACK: begin
            rlen_var <= 1'b1;
            rcnt     <= '0;
            st       <= ST_RDINTR;
            sr_load  <= 1'b1;
            sr_dir   <= 1'b0;
            treq_n   <= 1'b0;
          end
          ST_RDREPLY, ST_RDINTR: begin
            if (rlen_var) begin
              if (rxb > MAXB8) begin
                err_badlen <= 1'b1;
                st         <= ST_IDLE;
              end else if (rxb == 8'd0) begin
                rlen_var   <= 1'b0;
                done       <= 1'b1;
                done_count <= '0;
                done_intr  <= (st == ST_RDINTR);
                st         <= ST_IDLE;
                if (st == ST_RDREPLY && cur_def) awaiting <= 1'b1;
              end else begin
                rlen_var <= 1'b0;
                rlen     <= rxb;
                sr_load  <= 1'b1;
                sr_dir   <= 1'b0;
                treq_n   <= 1'b0;
              end
            end else begin
              rx_data  <= rxb;
              rx_valid <= 1'b1;
              rx_intr  <= (st == ST_RDINTR);
              rcnt     <= rcnt_inc;
              if (8'(rcnt_inc) < rlen) begin
                sr_load <= 1'b1;
                sr_dir  <= 1'b0;
                treq_n  <= 1'b0;
              end else begin
                done       <= 1'b1;
                done_count <= rcnt_inc;
                done_intr  <= (st == ST_RDINTR);
                st         <= ST_IDLE;
                if (st == ST_RDREPLY && cur_def) awaiting <= 1'b1;
              end
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  // R5
  done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!err_timeout && !err_badlen));

  // R7
  badlen_idle_chk: assert property (@(posedge clk) disable iff (rst)
    err_badlen |-> (st == ST_IDLE && !done));

  // R12
  defer_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && !pend && req_valid && req_deferred && awaiting && !defer_clr)
      |=> !req_accept);

  // R2
  load_treq_chk: assert property (@(posedge clk) disable iff (rst)
    sr_load |-> !treq_n);

  // R9
  intr_tag_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_intr) |-> $past(st == ST_RDINTR));
endmodule

// File: tb/tb_pmlink_seq.sv
module tb_pmlink_seq;
  localparam int MAXB = 32;
  localparam int NBW  = 6;
  localparam int AW   = 5;
  localparam int TMO  = 16;
  localparam logic [7:0] IOP = 8'h78;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic              req_valid = 0, req_deferred = 0, defer_clr = 0;
  logic [7:0]        req_opcode = 0;
  logic [NBW-1:0]    req_nbytes = 0;
  logic [MAXB*8-1:0] req_data = '0;
  logic              req_accept, req_reject;
  logic [7:0]        lut_op, lut_send, lut_reply;
  logic              treq_n, tack_n = 1, sr_load, sr_dir, sr_done = 0;
  logic [7:0]        sr_out, sr_in = 0;
  logic              attn = 0;
  logic [7:0]        rx_data;
  logic              rx_valid, rx_intr, done, done_intr, err_timeout, err_badlen;
  logic [NBW-1:0]    done_count;
  logic [AW-1:0]     ibuf_raddr = 0;
  logic [7:0]        ibuf_rdata;

  pmlink_seq #(.MAXB(MAXB), .NBW(NBW), .AW(AW), .ACK_TMO(TMO), .INTACK_OP(IOP)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_opcode(req_opcode),
    .req_nbytes(req_nbytes), .req_data(req_data), .req_deferred(req_deferred),
    .req_accept(req_accept), .req_reject(req_reject), .defer_clr(defer_clr),
    .lut_op(lut_op), .lut_send(lut_send), .lut_reply(lut_reply),
    .treq_n(treq_n), .tack_n(tack_n), .sr_load(sr_load), .sr_dir(sr_dir),
    .sr_out(sr_out), .sr_done(sr_done), .sr_in(sr_in), .attn(attn),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_intr(rx_intr), .done(done),
    .done_count(done_count), .done_intr(done_intr), .err_timeout(err_timeout),
    .err_badlen(err_badlen), .ibuf_raddr(ibuf_raddr), .ibuf_rdata(ibuf_rdata)
  );

  function automatic logic [15:0] lut(input logic [7:0] op);
    case (op)
      8'h10:   lut = {8'd1,   8'd0};
      8'h20:   lut = {8'hFF,  8'd0};
      8'h38:   lut = {8'd0,   8'd4};
      8'h28:   lut = {8'd0,   8'hFF};
      8'h3A:   lut = {8'd2,   8'hFF};
      8'h48:   lut = {8'hFF,  8'hFF};
      default: lut = {8'hFF,  8'd0};
    endcase
  endfunction
  assign lut_send  = lut(lut_op)[15:8];
  assign lut_reply = lut(lut_op)[7:0];

  int errors = 0, checks = 0;
  logic [7:0] tx_log [64];
  int tx_n = 0, in_n = 0, hs_viol = 0;
  logic [7:0] rx_log [64];
  logic       rxi_log [64];
  int rx_n = 0;
  int done_seen = 0, tmo_seen = 0, bad_seen = 0, acc_seen = 0, rej_seen = 0;
  logic [NBW-1:0] last_cnt = 0;
  logic last_intr = 0;
  logic [7:0] rq [64];
  int rp = 0;
  int hold = 2;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (sr_load && !tack_n) hs_viol++;
      if (rx_valid) begin rx_log[rx_n] = rx_data; rxi_log[rx_n] = rx_intr; rx_n++; end
      if (done) begin done_seen++; last_cnt = done_count; last_intr = done_intr; end
      if (err_timeout) tmo_seen++;
      if (err_badlen) bad_seen++;
      if (req_accept) acc_seen++;
      if (req_reject) rej_seen++;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (!rst && sr_load) begin
        logic d;
        d = sr_dir;
        if (d) begin tx_log[tx_n] = sr_out; tx_n++; end
        else in_n++;
        repeat (2) @(negedge clk);
        sr_in   = d ? 8'h00 : rq[rp];
        if (!d) rp++;
        sr_done = 1'b1;
        tack_n  = 1'b0;
        @(negedge clk);
        sr_done = 1'b0;
        repeat (hold) @(negedge clk);
        tack_n = 1'b1;
      end
    end
  end

  function automatic logic [7:0] dbyte(input logic [7:0] op, input int k);
    dbyte = op ^ 8'(k * 7 + 1);
  endfunction

  task automatic clear_logs();
    tx_n = 0; in_n = 0; rx_n = 0; rp = 0;
  endtask

  task automatic offer(input logic [7:0] op, input int nb, input bit dfr);
    @(negedge clk);
    req_opcode   = op;
    req_nbytes   = NBW'(nb);
    req_deferred = dfr;
    for (int k = 0; k < MAXB; k++) req_data[8*k +: 8] = dbyte(op, k);
    req_valid = 1'b1;
  endtask

  task automatic wait_resp(output int res, input int lim);
    res = 0;
    for (int c = 0; c < lim && res == 0; c++) begin
      @(negedge clk);
      if (req_accept) res = 1;
      else if (req_reject) res = 2;
    end
    req_valid = 1'b0;
  endtask

  task automatic wait_end(input int lim);
    int base;
    base = done_seen + tmo_seen + bad_seen;
    for (int c = 0; c < lim; c++) begin
      @(negedge clk);
      if (done_seen + tmo_seen + bad_seen > base) break;
    end
    repeat (3) @(negedge clk);
  endtask

  localparam int NV = 7;
  localparam logic [47:0] VEC [NV] = '{
    {8'h10, 8'd2, 8'd0,  8'd2, 8'd0,  8'd0},
    {8'h20, 8'd4, 8'd0,  8'd5, 8'd0,  8'd0},
    {8'h38, 8'd1, 8'd0,  8'd1, 8'd4,  8'd4},
    {8'h28, 8'd1, 8'd3,  8'd1, 8'd4,  8'd3},
    {8'h3A, 8'd3, 8'd0,  8'd3, 8'd1,  8'd0},
    {8'h48, 8'd1, 8'd32, 8'd2, 8'd33, 8'd32},
    {8'h20, 8'd1, 8'd0,  8'd2, 8'd0,  8'd0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int res;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(treq_n == 1'b1, "R1 treq_n", int'(treq_n), 1);
    check({req_accept, req_reject, sr_load, rx_valid, done, err_timeout, err_badlen} == 7'd0,
          "R1 pulses", int'({req_accept, req_reject, sr_load, rx_valid, done, err_timeout, err_badlen}), 0);

    for (int v = 0; v < NV; v++) begin
      logic [7:0] op, nb, rl, etx, ein, ecnt;
      bit ok;
      int d0;
      {op, nb, rl, etx, ein, ecnt} = VEC[v];
      clear_logs();
      if (lut(op)[7:0] == 8'hFF) begin
        rq[0] = rl;
        for (int k = 0; k < 40; k++) rq[k+1] = 8'hA0 + 8'(k);
      end else begin
        for (int k = 0; k < 40; k++) rq[k] = 8'hA0 + 8'(k);
      end
      d0 = done_seen;
      offer(op, int'(nb), 1'b0);
      wait_resp(res, 50);
      wait_end(2000);
      // R3 sent stream
      check(tx_n == int'(etx), "R3 tx count", tx_n, int'(etx));
      ok = (tx_log[0] == op);
      if (lut(op)[15:8] == 8'hFF) begin
        ok = ok && (tx_log[1] == nb - 8'd1);
        for (int k = 1; k < int'(nb); k++) ok = ok && (tx_log[k+1] == dbyte(op, k));
      end else begin
        for (int k = 1; k < int'(nb); k++) ok = ok && (tx_log[k] == dbyte(op, k));
      end
      check(ok, "R3 tx bytes", int'(tx_log[0]), int'(op));
      // R5 / R6 reply handling
      check(in_n == int'(ein), "R6 rx loads", in_n, int'(ein));
      check(done_seen == d0 + 1 && last_cnt == NBW'(ecnt) && !last_intr, "R5 done count",
            int'(last_cnt), int'(ecnt));
      ok = (rx_n == int'(ecnt));
      for (int k = 0; k < rx_n; k++) ok = ok && (rx_log[k] == 8'hA0 + 8'(k)) && !rxi_log[k];
      check(ok, "R6 rx bytes", rx_n, int'(ecnt));
    end

    // R4 rejects
    clear_logs();
    offer(8'h10, 3, 1'b0); wait_resp(res, 20);
    check(res == 2, "R4 fixed mismatch", res, 2);
    offer(8'h20, 0, 1'b0); wait_resp(res, 20);
    check(res == 2, "R4 zero bytes", res, 2);
    offer(8'h20, 33, 1'b0); wait_resp(res, 20);
    check(res == 2, "R4 over 32", res, 2);
    repeat (5) @(negedge clk);
    check(tx_n == 0, "R4 nothing sent", tx_n, 0);

    // R7 bad length
    clear_logs();
    rq[0] = 8'd40;
    begin
      int b0, d0;
      b0 = bad_seen; d0 = done_seen;
      offer(8'h28, 1, 1'b0); wait_resp(res, 20); wait_end(2000);
      check(bad_seen == b0 + 1, "R7 err_badlen", bad_seen - b0, 1);
      check(done_seen == d0, "R7 no done", done_seen - d0, 0);
    end

    // R8 timeout
    clear_logs();
    begin
      int t0, d0;
      t0 = tmo_seen; d0 = done_seen;
      hold = TMO + 10;
      offer(8'h10, 2, 1'b0); wait_resp(res, 20); wait_end(2000);
      check(tmo_seen == t0 + 1, "R8 err_timeout", tmo_seen - t0, 1);
      check(done_seen == d0, "R8 no done", done_seen - d0, 0);
      repeat (TMO + 20) @(negedge clk);
      hold = 2;
      clear_logs();
      offer(8'h10, 2, 1'b0); wait_resp(res, 20); wait_end(2000);
      check(done_seen == d0 + 1 && tx_n == 2, "R8 recovers", tx_n, 2);
    end

    // R9 R10 R11 attention preempts a waiting request
    clear_logs();
    rq[0] = 8'd2; rq[1] = 8'h55; rq[2] = 8'h66;
    offer(8'h20, 4, 1'b0); wait_resp(res, 20);
    @(negedge clk); attn = 1'b1;
    repeat (4) @(negedge clk); attn = 1'b0;
    offer(8'h10, 2, 1'b0); wait_resp(res, 2000);
    wait_end(2000);
    check(tx_n == 8 && tx_log[5] == IOP, "R10 intack first", int'(tx_log[5]), int'(IOP));
    check(tx_log[6] == 8'h10, "R10 queued after", int'(tx_log[6]), 16);
    check(rx_n == 2 && rxi_log[0] && rxi_log[1] && rx_log[0] == 8'h55 && rx_log[1] == 8'h66,
          "R9 intr bytes", rx_n, 2);
    ibuf_raddr = 0; @(negedge clk);
    check(ibuf_rdata == 8'h55, "R11 ibuf0", int'(ibuf_rdata), 85);
    ibuf_raddr = 1; @(negedge clk);
    check(ibuf_rdata == 8'h66, "R11 ibuf1", int'(ibuf_rdata), 102);

    // R9 attention alone from idle
    clear_logs();
    rq[0] = 8'd1; rq[1] = 8'h3C;
    attn = 1'b1; repeat (4) @(negedge clk); attn = 1'b0;
    wait_end(2000);
    check(tx_n == 1 && tx_log[0] == IOP && last_intr && last_cnt == 1, "R9 done_intr",
          int'(last_cnt), 1);

    // R12 deferred replies
    clear_logs();
    offer(8'h10, 2, 1'b1); wait_resp(res, 20); wait_end(2000);
    offer(8'h10, 2, 1'b0); wait_resp(res, 20); wait_end(2000);
    check(res == 1, "R12 plain accepted", res, 1);
    clear_logs();
    offer(8'h10, 2, 1'b1); wait_resp(res, 30);
    check(res == 0 && tx_n == 0, "R12 deferred held", res, 0);
    offer(8'h10, 2, 1'b1);
    @(negedge clk); defer_clr = 1'b1; @(negedge clk); defer_clr = 1'b0;
    wait_resp(res, 20); wait_end(2000);
    check(res == 1 && tx_n == 2, "R12 released", res, 1);

    // R2 handshake order
    check(hs_viol == 0, "R2 handshake", hs_viol, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule